// File: doc/BRIEF.md
# Four-Lane Bidirectional Serial-to-Parallel Output Driver

This block collects serial data on several lanes that share one clock and presents it as a wide parallel output word, one bank of outputs per lane. Each lane owns a shift register whose direction of travel is chosen by a single input. Every lane also offers a serial cascade output, so that several devices can be chained.

A latch stage sits behind the shift registers. While the latch enable is high it is transparent. While the enable is low it freezes the last value. An output gate then applies three controls in a fixed order: a global chip-select override, a blanking input for each bank, and a polarity inversion.

Use is simple. Shift a full frame into all lanes, pulse the latch enable, and control the visible result with chip select, blanking and polarity.

Top module: `serpar_driver`

## Requirements
- R1: With `dir_up`=1, each rising clock edge moves stage k to stage k+1 in every lane. `ser_in[b]` enters stage 1, and `casc_out[b]` shows stage 8 (the last stage).
- R2: With `dir_up`=0, each rising clock edge moves stage k to stage k-1 in every lane. `ser_in[b]` enters stage 8, and `casc_out[b]` shows stage 1.
- R3: While `rst`=1 at a rising edge, all shift stages and latches are cleared to 0. With `chip_sel`=1, all `blank_n` high and `pol`=1, every `drv_out` bit is then 0.
- R4: The level of `le` has no effect on shifting. Shift stages and `casc_out` advance identically whether `le` is high or low.
- R5: While `le`=1 the latch follows the shift stages, so after each edge the outputs reflect the new stage contents. While `le`=0 the latch holds, and the outputs stay constant as long as the gating inputs are unchanged.
- R6: `chip_sel`=0 forces all outputs to the inverse of `pol`, whatever the data and blanking.
- R7: With `chip_sel`=1, `blank_n[b]`=0 forces the 8 outputs of bank b to the inverse of `pol`. Other banks are unaffected.
- R8: With `chip_sel`=1 and `blank_n[b]`=1, `pol`=1 passes the latched bit unchanged and `pol`=0 inverts it.
- R9: Output bit `drv_out[b*8 + s-1]` carries stage s (1..8) of lane b. Lane b is fed by `ser_in[b]` and reported on `casc_out[b]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | LANES | Serial data, one bit per lane |
| dir_up | input | 1 | 1: shift toward higher stage, 0: toward lower stage |
| le | input | 1 | Latch enable, transparent while high |
| chip_sel | input | 1 | 0 forces every output to the inactive level |
| blank_n | input | LANES | Per-bank blanking, active low |
| pol | input | 1 | 1: pass data, 0: invert data |
| casc_out | output | LANES | Serial cascade output of each lane |
| drv_out | output | LANES*DEPTH | Gated parallel outputs, bank-major |

## Verification
The bench builds the block with its default parameters: four lanes of eight stages. With that size a complete frame takes eight clocks per lane, and a full-width output word can be compared bit for bit against the bench's reference of every lane at once. Pseudo-random lane data lets each bank carry different bits. This exposes any cross-lane or bit-order swap, and also a wrong entry stage in either direction. Long runs of clocks with the latch enable low show that shifting continues while the outputs stay frozen.

// File: rtl/sp_drv_pkg.sv
package sp_drv_pkg;

    localparam int unsigned LANES_DEF = 4;
    localparam int unsigned DEPTH_DEF = 8;

    typedef enum logic {
        SHIFT_DOWN = 1'b0,
        SHIFT_UP   = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic sel;
        logic pol;
    } gate_ctl_t;

    // Level driven by a bank that is deselected or blanked.
    function automatic logic idle_level(input logic pol);
        return ~pol;
    endfunction

endpackage

// File: rtl/lane_shifter.sv
module lane_shifter
    import sp_drv_pkg::*;
#(
    parameter int unsigned DEPTH = DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  shift_dir_e       dir,
    output logic [DEPTH-1:0] stages,
    output logic [DEPTH-1:0] stages_nxt,
    output logic             casc
);
    localparam int unsigned TOP = DEPTH - 1;

    always_comb begin
        if (dir == SHIFT_UP) begin
            stages_nxt = {stages[TOP-1:0], din};
        end else begin
            stages_nxt = {din, stages[TOP:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            stages <= stages_nxt;
        end
    end

    assign casc = (dir == SHIFT_UP) ? stages[TOP] : stages[0];

endmodule

// File: rtl/bank_latch.sv
module bank_latch
    import sp_drv_pkg::*;
#(
    parameter int unsigned DEPTH = DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             le,
    input  logic [DEPTH-1:0] stages,
    input  logic [DEPTH-1:0] stages_nxt,
    output logic [DEPTH-1:0] view
);
    logic [DEPTH-1:0] held;

    // Capture the post-edge value so that held matches the stages once le drops.
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (le) begin
            held <= stages_nxt;
        end
    end

    assign view = le ? stages : held;

endmodule

// File: rtl/out_gate.sv
module out_gate
    import sp_drv_pkg::*;
#(
    parameter int unsigned DEPTH = DEPTH_DEF
) (
    input  logic [DEPTH-1:0] view,
    input  gate_ctl_t        ctl,
    input  logic             blank_n,
    output logic [DEPTH-1:0] q
);
    always_comb begin
        if (!ctl.sel || !blank_n) begin
            q = {DEPTH{idle_level(ctl.pol)}};
        end else if (ctl.pol) begin
            q = view;
        end else begin
            q = ~view;
        end
    end

endmodule

// File: rtl/serpar_driver.sv
module serpar_driver
    import sp_drv_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned DEPTH = DEPTH_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       ser_in,
    input  logic                   dir_up,
    input  logic                   le,
    input  logic                   chip_sel,
    input  logic [LANES-1:0]       blank_n,
    input  logic                   pol,
    output logic [LANES-1:0]       casc_out,
    output logic [LANES*DEPTH-1:0] drv_out
);
    localparam int unsigned WIDTH = LANES * DEPTH;

    shift_dir_e       dir;
    gate_ctl_t        ctl;
    logic [WIDTH-1:0] sr_flat;
    logic [WIDTH-1:0] sr_nxt_flat;
    logic [WIDTH-1:0] view_flat;

    assign dir     = dir_up ? SHIFT_UP : SHIFT_DOWN;
    assign ctl.sel = chip_sel;
    assign ctl.pol = pol;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        lane_shifter #(.DEPTH(DEPTH)) shf_i (
            .clk        (clk),
            .rst        (rst),
            .din        (ser_in[b]),
            .dir        (dir),
            .stages     (sr_flat[b*DEPTH +: DEPTH]),
            .stages_nxt (sr_nxt_flat[b*DEPTH +: DEPTH]),
            .casc       (casc_out[b])
        );

        bank_latch #(.DEPTH(DEPTH)) lat_i (
            .clk        (clk),
            .rst        (rst),
            .le         (le),
            .stages     (sr_flat[b*DEPTH +: DEPTH]),
            .stages_nxt (sr_nxt_flat[b*DEPTH +: DEPTH]),
            .view       (view_flat[b*DEPTH +: DEPTH])
        );

        out_gate #(.DEPTH(DEPTH)) gate_i (
            .view    (view_flat[b*DEPTH +: DEPTH]),
            .ctl     (ctl),
            .blank_n (blank_n[b]),
            .q       (drv_out[b*DEPTH +: DEPTH])
        );
    end

endmodule

// File: rtl/serpar_driver_chk.sv
module serpar_driver_chk #(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [LANES-1:0]       ser_in,
    input logic                   dir_up,
    input logic                   le,
    input logic                   chip_sel,
    input logic [LANES-1:0]       blank_n,
    input logic                   pol,
    input logic [LANES-1:0]       casc_out,
    input logic [LANES*DEPTH-1:0] drv_out,
    input logic [LANES*DEPTH-1:0] sr_flat
);
    assert_reset_clear_R3: assert property (@(posedge clk)
        $past(rst) |-> (casc_out == '0 && sr_flat == '0));

    assert_cs_override_R6: assert property (@(posedge clk) disable iff (rst)
        !chip_sel |-> (drv_out == {(LANES*DEPTH){~pol}}));

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!le && !$past(le) && !$past(rst) && chip_sel == $past(chip_sel)
         && pol == $past(pol) && blank_n == $past(blank_n))
        |-> $stable(drv_out));

    for (genvar b = 0; b < LANES; b++) begin : g_chk
        assert_blank_bank_R7: assert property (@(posedge clk) disable iff (rst)
            (chip_sel && !blank_n[b]) |-> (drv_out[b*DEPTH +: DEPTH] == {DEPTH{~pol}}));

        assert_entry_up_R1: assert property (@(posedge clk) disable iff (rst)
            ($past(dir_up) && !$past(rst)) |-> (sr_flat[b*DEPTH] == $past(ser_in[b])));

        assert_entry_down_R2: assert property (@(posedge clk) disable iff (rst)
            (!$past(dir_up) && !$past(rst)) |-> (sr_flat[b*DEPTH+DEPTH-1] == $past(ser_in[b])));
    end

endmodule

bind serpar_driver serpar_driver_chk #(.LANES(LANES), .DEPTH(DEPTH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .dir_up   (dir_up),
    .le       (le),
    .chip_sel (chip_sel),
    .blank_n  (blank_n),
    .pol      (pol),
    .casc_out (casc_out),
    .drv_out  (drv_out),
    .sr_flat  (sr_flat)
);

// File: tb/serpar_driver_tb_top.sv
module serpar_driver_tb_top;
    localparam int unsigned LANES = 4;
    localparam int unsigned DEPTH = 8;
    localparam int unsigned WIDTH = LANES * DEPTH;

    typedef struct {
        string            tag;
        logic [LANES-1:0] casc;
        logic [WIDTH-1:0] drv;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] ser_in = '0;
    logic             dir_up = 1'b1;
    logic             le = 1'b1;
    logic             chip_sel = 1'b1;
    logic [LANES-1:0] blank_n = '1;
    logic             pol = 1'b1;
    logic [LANES-1:0] casc_out;
    logic [WIDTH-1:0] drv_out;

    exp_t             q[$];
    int               vectors = 0;
    int               misses = 0;
    bit               done = 1'b0;
    logic [15:0]      lfsr = 16'hACE1;
    logic [DEPTH-1:0] m_sr[LANES];
    logic [DEPTH-1:0] m_lat[LANES];

    always #10 clk = ~clk;

    serpar_driver #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .dir_up   (dir_up),
        .le       (le),
        .chip_sel (chip_sel),
        .blank_n  (blank_n),
        .pol      (pol),
        .casc_out (casc_out),
        .drv_out  (drv_out)
    );

    // Driver: apply one clock of stimulus, update the reference, push the expectation.
    task automatic step(input logic r, input logic d, input logic l, input logic c,
                        input logic [LANES-1:0] bl, input logic p, input string tag);
        exp_t e;
        logic [DEPTH-1:0] v;
        @(negedge clk);
        rst = r; dir_up = d; le = l; chip_sel = c; blank_n = bl; pol = p;
        ser_in = lfsr[LANES-1:0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        @(posedge clk);
        for (int b = 0; b < LANES; b++) begin
            if (r) begin
                m_sr[b] = '0;
                m_lat[b] = '0;
            end else begin
                if (d) m_sr[b] = {m_sr[b][DEPTH-2:0], ser_in[b]};
                else   m_sr[b] = {ser_in[b], m_sr[b][DEPTH-1:1]};
                if (l) m_lat[b] = m_sr[b];
            end
        end
        e.tag = tag;
        for (int b = 0; b < LANES; b++) begin
            v = l ? m_sr[b] : m_lat[b];
            if (!c || !bl[b]) v = {DEPTH{~p}};
            else if (!p) v = ~v;
            e.drv[b*DEPTH +: DEPTH] = v;
            e.casc[b] = d ? m_sr[b][DEPTH-1] : m_sr[b][0];
        end
        q.push_back(e);
    endtask

    // Monitor: compare a quarter period after each rising edge.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                e = q.pop_front();
                vectors++;
                if (drv_out !== e.drv || casc_out !== e.casc) begin
                    misses++;
                    $display("FAIL %s: drv=%h casc=%b expected drv=%h casc=%b",
                             e.tag, drv_out, casc_out, e.drv, e.casc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < LANES; b++) begin
            m_sr[b] = '0;
            m_lat[b] = '0;
        end
        // R3: reset clears stages and latches
        repeat (2) step(1, 1, 1, 1, '1, 1, "R3");
        // R4: shifting upward with le low, outputs frozen at zero
        repeat (DEPTH) step(0, 1, 0, 1, '1, 1, "R4");
        // R5 / R9: transparent latch shows stages per bank
        repeat (3) step(0, 1, 1, 1, '1, 1, "R9");
        // R1: full upward traversal with transparent latch
        repeat (DEPTH) step(0, 1, 1, 1, '1, 1, "R1");
        // R5: hold while shifting continues
        repeat (5) step(0, 1, 0, 1, '1, 1, "R5");
        // R8: inversion with polarity low
        repeat (3) step(0, 1, 0, 1, '1, 0, "R8");
        step(0, 1, 1, 1, '1, 0, "R8");
        // R7: blanking single banks in both polarities
        step(0, 1, 0, 1, 4'b1101, 1, "R7");
        step(0, 1, 0, 1, 4'b1101, 0, "R7");
        step(0, 1, 1, 1, 4'b0110, 1, "R7");
        // R6: chip select override beats blanking and data
        step(0, 1, 1, 0, 4'b0101, 1, "R6");
        step(0, 1, 1, 0, '1, 0, "R6");
        step(0, 1, 0, 0, '1, 1, "R6");
        // R2: downward traversal, then latch
        repeat (DEPTH) step(0, 0, 0, 1, '1, 1, "R2");
        repeat (DEPTH + 2) step(0, 0, 1, 1, '1, 1, "R2");
        // R4: direction flips with le low, hold verified
        repeat (4) step(0, 1, 0, 1, '1, 0, "R4");
        repeat (4) step(0, 0, 0, 1, '1, 1, "R4");
        // R3: reset mid-run
        step(1, 0, 0, 1, '1, 1, "R3");
        step(0, 1, 1, 1, '1, 1, "R3");
        @(posedge clk);
        #8;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule